// File: doc/BRIEF.md
# Montgomery Modular Multiplier (16-bit, handshaked multiply unit)

The block computes `(A * B) mod N` for a 16-bit odd modulus N using Montgomery reduction with `R = 2^16`. The caller supplies the two operands, the modulus and two constants that it computes beforehand: `NINV = -N^-1 mod R` and `RSQ = R^2 mod N`. A one-cycle `start` in the idle state loads all five values into internal registers. While the block works, `busy` is high. `done` pulses for one cycle when `result` carries the product, and `result` holds that value until the next completion.

The work runs as four Montgomery reduction steps in a fixed order. Step 1 maps A into the Montgomery domain by reducing `A*RSQ`, and step 2 does the same for B. Step 3 reduces the product of the two mapped values. Step 4 maps the result back by reducing it against the constant 1.

Each step is a chain of three dependent integer products: `T = x*y`, `M = (T mod R)*NINV mod R` and `P = M*N`. The step then forms `U = (T + P) / R` and subtracts N once if `U >= N`. Every product runs on one shared multiply unit. That unit adds 16 partial products in a tree of 3:2 carry-save adders, followed by one carry-propagate adder. The controller reaches it over a four-phase req/ack handshake.

The controller states are IDLE, ISSUE, WAIT, FIX and DONE:
- IDLE→ISSUE happens on `start`, and the operands are captured at that edge.
- ISSUE→WAIT raises the request once the previous acknowledge has dropped. ISSUE stays in place while acknowledge is still high.
- WAIT→ISSUE stores a product and moves on to the next product of the chain. WAIT→FIX stores the third product of a step.
- FIX→ISSUE stores the reduced value of steps 1 to 3. FIX→DONE stores the value of step 4 as the result.
- DONE→IDLE is unconditional.

The multiply unit has two states, IDLE and HOLD. IDLE→HOLD happens on a request and captures the product. HOLD→IDLE happens when the request falls.

Top module: `mont_modmul`

## Requirements
- R1: During reset and at reset release, `busy`, `done` and `result` are all 0.
- R2: For any 16-bit A and B, any odd N from 1 to 65535 and the matching NINV and RSQ, the block reports `(A*B) mod N`. This includes A=0, B=N-1, N=1 and operands not below N.
- R3: `start` is taken only in the idle state. Counting the edge that samples it as edge 0, `busy` is high from edge 0 up to and including edge 48, and low again after edge 49.
- R4: A `start` pulse or any operand change while `busy` is high does not alter the running job, its timing or its result.
- R5: `done` is high for exactly one cycle, the cycle after edge 48.
- R6: `result` changes only in the cycle in which `done` is high, and it holds its value otherwise.
- R7: The controller holds the request and both multiply operands stable from the request until the acknowledge. The acknowledge rises only in answer to a request.
- R8: While both request and acknowledge are high, the multiply unit's 32-bit product equals the exact product of its two 16-bit operands.
- R9: In every reduction, the low 16 bits of `T + P` are zero and `U < 2N`.
- R10: A reported result is always below the captured modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a job when the block is idle |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| modulus | input | 16 | Odd modulus N |
| n_inv | input | 16 | Precomputed `-N^-1 mod 2^16` |
| r_sq | input | 16 | Precomputed `2^32 mod N` |
| busy | output | 1 | High while a job is running, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | `(A*B) mod N`, held between completions |

## Verification
Every reduction step takes exactly 12 cycles: three handshaked products at three or four cycles each, then the fix-up cycle. The full job is therefore fixed, and `done` with the new `result` is due 48 edges after the edge that samples `start`. The bench keeps an edge counter that starts at that accepting edge. From it, the bench predicts `busy`, `done` and `result` for every cycle and compares them half a period after each edge, so an early, late or doubled pulse fails in the exact cycle where it happens. A `start` given mid-job is invisible to the counter, so any restart or timing change it caused would show as a mismatch.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_ISSUE,
        C_WAIT,
        C_FIX,
        C_DONE
    } ctrl_st_t;

    typedef enum logic {
        M_IDLE,
        M_HOLD
    } mul_st_t;

    // Order of the four reduction steps; the controller walks them in sequence.
    typedef enum logic [1:0] {
        STEP_A_IN,
        STEP_B_IN,
        STEP_PROD,
        STEP_OUT
    } step_t;

endpackage

// File: rtl/mm_csa_tree.sv
module mm_csa_tree #(
    parameter int W = 16
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] prod
);
    localparam int PW  = 2 * W;
    localparam int NPP = W;

    logic [PW-1:0] pp [NPP];

    // One shifted partial product per multiplier bit.
    for (genvar i = 0; i < NPP; i++) begin : g_pp
        assign pp[i] = y[i] ? (PW'(x) << i) : '0;
    end

    // Repeated 3:2 reduction: each level takes rows in groups of three and
    // replaces every group by a sum row and a shifted carry row.
    always_comb begin
        logic [PW-1:0] cur [NPP];
        logic [PW-1:0] nxt [NPP];
        int cnt;
        int grp;
        int rest;
        cur = pp;
        cnt = NPP;
        for (int lvl = 0; lvl < NPP; lvl++) begin
            if (cnt > 2) begin
                grp  = cnt / 3;
                rest = cnt - 3 * grp;
                for (int k = 0; k < NPP; k++) begin
                    nxt[k] = '0;
                end
                for (int g = 0; g < NPP / 3; g++) begin
                    if (g < grp) begin
                        nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                        nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) |
                                      (cur[3*g] & cur[3*g+2]) |
                                      (cur[3*g+1] & cur[3*g+2])) << 1;
                    end
                end
                for (int r = 0; r < 2; r++) begin
                    if (r < rest) begin
                        nxt[2*grp+r] = cur[3*grp+r];
                    end
                end
                cur = nxt;
                cnt = 2 * grp + rest;
            end
        end
        // Final carry-propagate adder.
        prod = cur[0] + cur[1];
    end

endmodule

// File: rtl/mm_mul_unit.sv
module mm_mul_unit
    import mm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [W-1:0]   op_x,
    input  logic [W-1:0]   op_y,
    output logic           ack,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    mul_st_t       st, st_nx;
    logic [PW-1:0] tree_sum;
    logic [PW-1:0] prod_q;

    mm_csa_tree #(.W(W)) u_tree (
        .x    (op_x),
        .y    (op_y),
        .prod (tree_sum)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            M_IDLE: if (req)  st_nx = M_HOLD;
            M_HOLD: if (!req) st_nx = M_IDLE;
            default:          st_nx = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= M_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  prod_q <= '0;
        else if (st == M_IDLE && req) prod_q <= tree_sum;
    end

    assign ack  = (st == M_HOLD);
    assign prod = prod_q;

    p_ack_answers_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));

    p_prod_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |-> (prod == PW'(op_x) * PW'(op_y)));

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [W-1:0]   modulus,
    input  logic [W-1:0]   n_inv,
    input  logic [W-1:0]   r_sq,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   result,
    output logic           mul_req,
    output logic [W-1:0]   mul_x,
    output logic [W-1:0]   mul_y,
    input  logic           mul_ack,
    input  logic [2*W-1:0] mul_prod
);
    localparam int         PW       = 2 * W;
    localparam logic [1:0] LAST_MUL = 2'd2;
    localparam logic [W-1:0] ONE    = W'(1);

    ctrl_st_t st, st_nx;
    step_t    step;
    logic [1:0] idx;

    logic [W-1:0]  a_q, b_q, n_q, ni_q, rs_q;
    logic [PW-1:0] t_q, pn_q;
    logic [W-1:0]  m_q;
    logic [W-1:0]  am_q, bm_q, pm_q, res_q;
    logic          req_q;

    logic [W-1:0]  src_x, src_y;
    logic [PW:0]   sum_full;
    logic [W:0]    u_val;
    logic [W:0]    n_ext;
    logic [W-1:0]  red_val;

    // First product of each step picks its operands by step.
    always_comb begin
        unique case (step)
            STEP_A_IN: begin src_x = a_q;  src_y = rs_q; end
            STEP_B_IN: begin src_x = b_q;  src_y = rs_q; end
            STEP_PROD: begin src_x = am_q; src_y = bm_q; end
            STEP_OUT:  begin src_x = pm_q; src_y = ONE;  end
            default:   begin src_x = '0;   src_y = '0;   end
        endcase
    end

    always_comb begin
        unique case (idx)
            2'd0:    begin mul_x = src_x;         mul_y = src_y; end
            2'd1:    begin mul_x = t_q[W-1:0];    mul_y = ni_q;  end
            default: begin mul_x = m_q;           mul_y = n_q;   end
        endcase
    end

    // Reduction: (T + M*N) / R, then one conditional subtract.
    assign sum_full = {1'b0, t_q} + {1'b0, pn_q};
    assign u_val    = sum_full[PW:W];
    assign n_ext    = {1'b0, n_q};
    assign red_val  = (u_val >= n_ext) ? W'(u_val - n_ext) : u_val[W-1:0];

    always_comb begin
        st_nx = st;
        unique case (st)
            C_IDLE:  if (start)    st_nx = C_ISSUE;
            C_ISSUE: if (!mul_ack) st_nx = C_WAIT;
            C_WAIT:  if (mul_ack)  st_nx = (idx == LAST_MUL) ? C_FIX : C_ISSUE;
            C_FIX:   st_nx = (step == STEP_OUT) ? C_DONE : C_ISSUE;
            C_DONE:  st_nx = C_IDLE;
            default: st_nx = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step  <= STEP_A_IN;
            idx   <= '0;
            a_q   <= '0;
            b_q   <= '0;
            n_q   <= '0;
            ni_q  <= '0;
            rs_q  <= '0;
            t_q   <= '0;
            pn_q  <= '0;
            m_q   <= '0;
            am_q  <= '0;
            bm_q  <= '0;
            pm_q  <= '0;
            res_q <= '0;
            req_q <= 1'b0;
        end else begin
            unique case (st)
                C_IDLE: begin
                    if (start) begin
                        a_q  <= op_a;
                        b_q  <= op_b;
                        n_q  <= modulus;
                        ni_q <= n_inv;
                        rs_q <= r_sq;
                        step <= STEP_A_IN;
                        idx  <= '0;
                    end
                end
                C_ISSUE: begin
                    if (!mul_ack) req_q <= 1'b1;
                end
                C_WAIT: begin
                    if (mul_ack) begin
                        req_q <= 1'b0;
                        unique case (idx)
                            2'd0:    t_q  <= mul_prod;
                            2'd1:    m_q  <= mul_prod[W-1:0];
                            default: pn_q <= mul_prod;
                        endcase
                        idx <= (idx == LAST_MUL) ? 2'd0 : idx + 2'd1;
                    end
                end
                C_FIX: begin
                    unique case (step)
                        STEP_A_IN: am_q  <= red_val;
                        STEP_B_IN: bm_q  <= red_val;
                        STEP_PROD: pm_q  <= red_val;
                        default:   res_q <= red_val;
                    endcase
                    if (step != STEP_OUT) step <= step_t'(step + 2'd1);
                end
                C_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign busy    = (st != C_IDLE);
    assign done    = (st == C_DONE);
    assign result  = res_q;
    assign mul_req = req_q;

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req && !mul_ack) |=> (mul_req && $stable(mul_x) && $stable(mul_y)));

    p_low_half_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_FIX) |-> (sum_full[W-1:0] == '0));

    p_u_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_FIX) |-> (u_val < {n_q, 1'b0}));

    p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    p_result_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < n_q));

endmodule

// File: rtl/mont_modmul.sv
module mont_modmul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] n_inv,
    input  logic [W-1:0] r_sq,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int PW = 2 * W;

    logic          mul_req;
    logic          mul_ack;
    logic [W-1:0]  mul_x;
    logic [W-1:0]  mul_y;
    logic [PW-1:0] mul_prod;

    mm_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_a     (op_a),
        .op_b     (op_b),
        .modulus  (modulus),
        .n_inv    (n_inv),
        .r_sq     (r_sq),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .mul_req  (mul_req),
        .mul_x    (mul_x),
        .mul_y    (mul_y),
        .mul_ack  (mul_ack),
        .mul_prod (mul_prod)
    );

    mm_mul_unit #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mul_req),
        .op_x  (mul_x),
        .op_y  (mul_y),
        .ack   (mul_ack),
        .prod  (mul_prod)
    );

endmodule

// File: tb/mont_modmul_tb.sv
module mont_modmul_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 48;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, modulus = 16'd1, n_inv = '0, r_sq = '0;
    logic        busy, done;
    logic [15:0] result;

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string tag = "R2";

    // Behavioural model state
    bit     m_active = 1'b0;
    int     m_cnt    = 0;
    longint m_exp    = 0;
    longint m_shown  = 0;
    longint m_n      = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mont_modmul u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .modulus (modulus),
        .n_inv   (n_inv),
        .r_sq    (r_sq),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    function automatic logic [15:0] calc_ninv(input logic [15:0] n);
        logic [15:0] inv;
        inv = n;
        for (int i = 0; i < 5; i++) inv = inv * (16'd2 - n * inv);
        return 16'd0 - inv;
    endfunction

    function automatic logic [15:0] calc_rsq(input logic [15:0] n);
        longint t;
        t = 64'h1_0000_0000 % longint'(n);
        return t[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Edge counter model: accepting edge is count 0, done at count LAT.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0;
            m_cnt    = 0;
            m_shown  = 0;
        end else if (m_active) begin
            m_cnt++;
            if (m_cnt == LAT) m_shown = m_exp;
            if (m_cnt == LAT + 1) m_active = 1'b0;
        end else if (start) begin
            m_active = 1'b1;
            m_cnt    = 0;
            m_n      = longint'(modulus);
            m_exp    = (longint'(op_a) * longint'(op_b)) % longint'(modulus);
        end
    end

    // Per-cycle comparison half a period after each edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            // R3, R7: the fixed busy window also depends on the handshake pacing
            check(busy == m_active, "R3", longint'(busy), longint'(m_active), "busy");
            check(done == (m_active && m_cnt == LAT), "R5", longint'(done),
                  longint'(m_active && m_cnt == LAT), "done");
            if (m_active && m_cnt == LAT) begin
                // R8, R9: a wrong product or reduction shows up in this value
                check(longint'(result) == m_shown, tag, longint'(result), m_shown, "result");
                check(longint'(result) < m_n, "R10", longint'(result), m_n, "result below modulus");
            end else begin
                check(longint'(result) == m_shown, "R6", longint'(result), m_shown, "held result");
            end
        end
    end

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [15:0] n);
        @(negedge clk);
        op_a    = a;
        op_b    = b;
        modulus = n;
        n_inv   = calc_ninv(n);
        r_sq    = calc_rsq(n);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [15:0] n,
                          input string t);
        tag = t;
        drive(a, b, n);
        wait_idle();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            report();
        end
    end

    initial begin
        // R1: reset state, during reset and just after release
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", longint'(busy), 0, "busy in reset");
        check(done == 1'b0, "R1", longint'(done), 0, "done in reset");
        check(result == '0, "R1", longint'(result), 0, "result in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && result == '0, "R1",
              longint'({busy, done, result}), 0, "state after release");

        // R2 edge cases
        run_op(16'd0,     16'd5,     16'd7,     "R2");
        run_op(16'd3,     16'hFFF0,  16'hFFF1,  "R2");
        run_op(16'hFFFF,  16'hFFFF,  16'd1,     "R2");
        run_op(16'hFFFE,  16'hFFFE,  16'hFFFF,  "R2");
        run_op(16'hFFFF,  16'h1234,  16'h0101,  "R2");
        run_op(16'd1,     16'd1,     16'd3,     "R2");

        // R4: start and new operands mid-job are ignored
        tag = "R4";
        drive(16'h4321, 16'h8765, 16'hC001);
        repeat (10) @(negedge clk);
        op_a    = 16'h1111;
        op_b    = 16'h2222;
        modulus = 16'h0033;
        n_inv   = calc_ninv(16'h0033);
        r_sq    = calc_rsq(16'h0033);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wait_idle();

        // R6: idle with changed inputs and no start, result must hold
        op_a = 16'hAAAA;
        op_b = 16'h5555;
        repeat (6) @(negedge clk);

        // R3: start held high, accepted only at idle edges (back-to-back jobs)
        tag     = "R3";
        op_a    = 16'h0F0F;
        op_b    = 16'hF0F0;
        modulus = 16'hBEEF;
        n_inv   = calc_ninv(16'hBEEF);
        r_sq    = calc_rsq(16'hBEEF);
        start   = 1'b1;
        repeat (2 * LAT + 10) @(negedge clk);
        start   = 1'b0;
        wait_idle();

        // R2: random operands, random odd moduli
        for (int i = 0; i < 40; i++) begin
            logic [15:0] ra, rb, rn;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rn = 16'($urandom) | 16'd1;
            run_op(ra, rb, rn, "R2");
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        report();
    end

endmodule